// File: doc/BRIEF.md
# Byte-Stallable Serial Configuration Register Slave

This block is a serial slave that lets a host read and write a 128-entry bank of 8-bit configuration registers. It runs on a fast system clock and oversamples the serial clock and the active-low select, both of which are taken as already synchronous to that clock. Every transaction is two bytes long. The first byte is an instruction. Its top bit asks for a read (1) or a write (0), and its low seven bits name a register. The second byte carries the data.

Register 0 lives inside the block and sets how the port behaves. Bit 7 set to 1 gives a 3-wire port, where read data goes out on the shared data line. Bit 7 at 0 gives a 4-wire port, where read data goes out on a separate output. Bit 6 set to 1 sends bits least-significant first. Registers 1 to 127 sit outside the block and are reached through a simple register-file port.

The host may raise select between bytes to pause a transaction and pick it up later. Raising select in the middle of a byte throws away the partial transaction.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset, register 0 reads 0x00 (4-wire port, MSB first). Both output enables are low and no register-file write is issued.
- R2: The first eight serial-clock rising edges after select falls assemble the instruction byte. In the assembled byte, bit 7 = 1 means read and bits 6..0 give the register address.
- R3: A write to an address from 1 to 127 produces exactly one `rf_wr_en` pulse of one clock. The pulse comes after the 16th rising edge and carries that address and the assembled data byte.
- R4: In 4-wire mode, a read drives data bit k on `sdo` after rising edge 8+k. `sdo_oe` is high during the data byte, and `sdio_oe` stays low.
- R5: In 3-wire mode, a read drives the data on `sdio_out` with `sdio_oe` high during the data byte, and `sdo_oe` is never asserted.
- R6: The active output enable falls once the read data byte completes, even while select stays low.
- R7: While `cs_n` is high, `sdio_oe` and `sdo_oe` are both low.
- R8: Raising `cs_n` after 0 or 8 bits of a transaction pauses it. Lowering `cs_n` again continues it with the next bit, including read data already loaded.
- R9: Raising `cs_n` after any other bit count discards the transaction, issues no write, and makes the next bit the first instruction bit.
- R10: Register 0 is stored inside the block: bit 7 = 3-wire mode, bit 6 = LSB first. Writes to it never reach the register-file port, and reads of it return the stored byte.
- R11: With LSB first set, both instruction and data bytes go least-significant bit first. A change of order applies from the next instruction byte.
- R12: If select stays low after a transaction's 16th edge, the next edges form a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low select |
| sdio_in | input | 1 | Serial data into the block (both modes) |
| sdio_out | output | 1 | Read data for the shared line in 3-wire mode |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo | output | 1 | Read data for the separate output in 4-wire mode |
| sdo_oe | output | 1 | Drive enable for the separate output |
| rf_addr | output | 7 | Register-file address of the current transaction |
| rf_wr_en | output | 1 | One-clock register-file write strobe |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data for `rf_addr`, combinational |

## Verification
Two things can happen in the same transaction frame: a write to register 0 commits, and the next instruction, with select still low, starts shifting in under the new settings. The bench triggers this by writing register 0 and issuing a read straight after it, without raising select. The read's instruction bits are sent in the order the write just selected. The read is judged correct if the right data comes back on the pin chosen by the new mode setting. Pauses at byte boundaries and aborts in mid-byte are also placed next to pending read data and pending writes. This shows that a pause keeps the loaded byte, and that an abort drops it without any write.

// File: rtl/cfg_spi_pkg.sv
// Package: shared types for the serial configuration slave.
// Assumes register 0 keeps its mode bits at the top of the byte.
package cfg_spi_pkg;
    // Offsets of the mode bits in register 0, counted down from its MSB
    localparam int BIDIR_FROM_MSB = 0;
    localparam int LSBF_FROM_MSB  = 1;

    // Decoded pin configuration taken from register 0
    typedef struct packed {
        logic bidir;
        logic lsb_first;
    } pin_cfg_t;
endpackage

// File: rtl/cfg_spi_edge.sv
// Module: detects serial-clock rising edges and select rising edges.
// Assumes sclk and cs_n are already synchronous to clk and change slowly
// compared with it.
module cfg_spi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_rise,
    output logic cs_rise
);
    logic sclk_q;
    logic cs_q;

    // Delay both lines by one clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign sclk_rise = sclk & ~sclk_q & ~cs_n;
    assign cs_rise   = cs_n & ~cs_q;
endmodule

// File: rtl/cfg_spi_shift.sv
// Module: bit counter and input shift register for the two-byte frame.
// Produces one-clock strobes after the last instruction bit and the last
// data bit. A select rise off a byte boundary clears the counter.
// Assumes sclk_rise and cs_rise never occur in the same clock.
module cfg_spi_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              cs_rise,
    input  logic              sdi,
    input  logic              lsb_first,
    output logic [DATA_W-1:0] byte_q,
    output logic              instr_done,
    output logic              data_done,
    output logic              port_reset
);
    localparam int CNT_W = $clog2(2 * DATA_W);
    localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(2 * DATA_W - 1);
    localparam logic [CNT_W-1:0] MID_FRAME  = CNT_W'(DATA_W);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh_next;
    logic              on_boundary;

    // Byte boundary: frame start or between instruction and data
    assign on_boundary = (cnt == '0) || (cnt == MID_FRAME);
    assign port_reset  = cs_rise & ~on_boundary;

    // Next shift value in the selected bit order
    always_comb begin
        if (lsb_first) sh_next = {sdi, byte_q[DATA_W-1:1]};
        else           sh_next = {byte_q[DATA_W-2:0], sdi};
    end

    // Count bits, shift data, and flag byte completions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            byte_q     <= '0;
            instr_done <= 1'b0;
            data_done  <= 1'b0;
        end else begin
            instr_done <= 1'b0;
            data_done  <= 1'b0;
            if (port_reset) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                byte_q     <= sh_next;
                instr_done <= (cnt == LAST_INSTR);
                data_done  <= (cnt == LAST_DATA);
                cnt        <= (cnt == LAST_DATA) ? '0 : cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_spi_ctrl.sv
// Module: transaction control, register 0 storage, register-file access
// and read-data serialiser with output enables.
// Assumes the instruction MSB is the read flag and the rest is the address.
module cfg_spi_ctrl
    import cfg_spi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic              instr_done,
    input  logic              data_done,
    input  logic              port_reset,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [DATA_W-1:0] rf_rdata,
    output pin_cfg_t          pin_cfg,
    output logic [DATA_W-2:0] rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int ADDR_W   = DATA_W - 1;
    localparam int BIDIR_IX = DATA_W - 1 - BIDIR_FROM_MSB;
    localparam int LSBF_IX  = DATA_W - 1 - LSBF_FROM_MSB;

    logic [DATA_W-1:0] cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic              load_q;
    logic              rd_active;
    logic [DATA_W-1:0] tx_q;
    logic              out_bit;

    assign pin_cfg.bidir     = cfg_q[BIDIR_IX];
    assign pin_cfg.lsb_first = cfg_q[LSBF_IX];
    assign rf_addr           = addr_q;

    // Latch instruction, commit writes, keep register 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            addr_q   <= '0;
            rd_q     <= 1'b0;
            rf_wr_en <= 1'b0;
            rf_wdata <= '0;
        end else begin
            rf_wr_en <= 1'b0;
            if (instr_done) begin
                rd_q   <= byte_in[DATA_W-1];
                addr_q <= byte_in[ADDR_W-1:0];
            end
            if (data_done && !rd_q) begin
                if (addr_q == '0) begin
                    cfg_q <= byte_in;
                end else begin
                    rf_wr_en <= 1'b1;
                    rf_wdata <= byte_in;
                end
            end
        end
    end

    // Load and shift out read data; track the read data window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q    <= 1'b0;
            rd_active <= 1'b0;
            tx_q      <= '0;
        end else if (port_reset || data_done) begin
            load_q    <= 1'b0;
            rd_active <= 1'b0;
        end else if (instr_done) begin
            load_q <= byte_in[DATA_W-1];
        end else if (load_q) begin
            load_q    <= 1'b0;
            rd_active <= 1'b1;
            tx_q      <= (addr_q == '0) ? cfg_q : rf_rdata;
        end else if (sclk_rise && rd_active) begin
            tx_q <= pin_cfg.lsb_first ? (tx_q >> 1) : (tx_q << 1);
        end
    end

    // Current output bit and per-mode enables
    assign out_bit  = pin_cfg.lsb_first ? tx_q[0] : tx_q[DATA_W-1];
    assign sdio_out = out_bit;
    assign sdo      = out_bit;
    assign sdio_oe  = ~cs_n & rd_active & pin_cfg.bidir;
    assign sdo_oe   = ~cs_n & rd_active & ~pin_cfg.bidir;
endmodule

// File: rtl/cfg_spi_slave.sv
// Module: top of the byte-stallable serial configuration slave.
// Assumes sclk and cs_n are synchronous to clk, each level lasting
// at least three clocks.
module cfg_spi_slave
    import cfg_spi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [DATA_W-2:0] rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic              sclk_rise;
    logic              cs_rise;
    logic [DATA_W-1:0] byte_q;
    logic              instr_done;
    logic              data_done;
    logic              port_reset;
    pin_cfg_t          pin_cfg;

    cfg_spi_edge edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise),
        .cs_rise   (cs_rise)
    );

    cfg_spi_shift #(.DATA_W(DATA_W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .cs_rise    (cs_rise),
        .sdi        (sdio_in),
        .lsb_first  (pin_cfg.lsb_first),
        .byte_q     (byte_q),
        .instr_done (instr_done),
        .data_done  (data_done),
        .port_reset (port_reset)
    );

    cfg_spi_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk_rise  (sclk_rise),
        .instr_done (instr_done),
        .data_done  (data_done),
        .port_reset (port_reset),
        .byte_in    (byte_q),
        .rf_rdata   (rf_rdata),
        .pin_cfg    (pin_cfg),
        .rf_addr    (rf_addr),
        .rf_wr_en   (rf_wr_en),
        .rf_wdata   (rf_wdata),
        .sdio_out   (sdio_out),
        .sdio_oe    (sdio_oe),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );
endmodule

// File: rtl/cfg_spi_slave_chk.sv
// Module: protocol checker bound to cfg_spi_slave.
// Assumes it sees only the top-level ports.
module cfg_spi_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdio_oe,
    input logic              sdo_oe,
    input logic              rf_wr_en,
    input logic [DATA_W-2:0] rf_addr
);
    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    // R10
    wr_not_reg0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (rf_addr != '0));

    // R5
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdio_oe, sdo_oe}));

    // R7
    released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sdio_oe && !sdo_oe));

    // R6
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (!sdio_oe && !sdo_oe));
endmodule

bind cfg_spi_slave cfg_spi_slave_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdio_oe  (sdio_oe),
    .sdo_oe   (sdo_oe),
    .rf_wr_en (rf_wr_en),
    .rf_addr  (rf_addr)
);

// File: tb/cfg_spi_slave_tb_top.sv
// Bench for cfg_spi_slave: vector loop, then directed corner tests.
module cfg_spi_slave_tb_top;
    localparam int HALF = 4;
    localparam int NVEC = 8;
    // {address, data}
    localparam logic [14:0] VECS [NVEC] = '{
        {7'h01, 8'hA5}, {7'h02, 8'h5A}, {7'h7F, 8'hFF}, {7'h40, 8'h00},
        {7'h15, 8'h81}, {7'h2A, 8'h7E}, {7'h03, 8'hC3}, {7'h7E, 8'h01}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdio_in = 1'b0;
    logic       sdio_out, sdio_oe, sdo, sdo_oe, rf_wr_en;
    logic [6:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;
    logic [7:0] rf_mem [128];

    int checks = 0, errors = 0, wr_count = 0, oe_bad = 0;
    logic [6:0] last_addr = '0;
    logic [7:0] last_data = '0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    cfg_spi_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdo(sdo), .sdo_oe(sdo_oe), .rf_addr(rf_addr), .rf_wr_en(rf_wr_en),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    assign rf_rdata = rf_mem[rf_addr];

    // Bench-side register file and write monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) rf_mem[i] <= 8'h00;
        end else if (rf_wr_en) begin
            rf_mem[rf_addr] <= rf_wdata;
            wr_count  <= wr_count + 1;
            last_addr <= rf_addr;
            last_data <= rf_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cs_lo();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi();
        @(negedge clk) cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // One serial bit; returns the read pin value seen just before the edge
    task automatic one_bit(input bit b, input bit bidir, input bit exp_oe, output bit seen);
        @(negedge clk);
        sdio_in = b;
        seen = bidir ? sdio_out : sdo;
        if ((bidir ? sdio_oe : sdo_oe) !== exp_oe) oe_bad++;
        if ((bidir ? sdo_oe : sdio_oe) !== 1'b0) oe_bad++;
        repeat (HALF - 1) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic byte_io(input logic [7:0] b, input bit lsb, input bit bidir,
                           input bit exp_oe, output logic [7:0] rd);
        rd = '0;
        for (int i = 0; i < 8; i++) begin
            bit s;
            one_bit(lsb ? b[i] : b[7-i], bidir, exp_oe, s);
            if (lsb) rd[i] = s; else rd[7-i] = s;
        end
    endtask

    // Full two-byte transaction, select already low
    task automatic xact(input bit rw, input logic [6:0] a, input logic [7:0] d,
                        input bit lsb, input bit bidir, output logic [7:0] rd);
        logic [7:0] dummy;
        byte_io({rw, a}, lsb, bidir, 1'b0, dummy);
        byte_io(d, lsb, bidir, rw, rd);
        repeat (HALF) @(negedge clk);
    endtask

    task automatic framed(input bit rw, input logic [6:0] a, input logic [7:0] d,
                          input bit lsb, input bit bidir, output logic [7:0] rd);
        cs_lo();
        xact(rw, a, d, lsb, bidir, rd);
        cs_hi();
    endtask

    initial begin
        logic [7:0] rd;
        int wc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(!sdio_oe && !sdo_oe, "R1 oe after reset", {sdio_oe, sdo_oe}, 0);
        chk(wr_count == 0, "R1 no write after reset", wr_count, 0);
        oe_bad = 0;
        framed(1'b1, 7'h00, 8'h00, 1'b0, 1'b0, rd);
        chk(rd == 8'h00, "R1 reg0 default", rd, 8'h00);
        chk(oe_bad == 0, "R4 enables on reg0 read", oe_bad, 0);

        // R2 R3 R4: vector table, write then read back
        for (int v = 0; v < NVEC; v++) begin
            wc = wr_count;
            framed(1'b0, VECS[v][14:8], VECS[v][7:0], 1'b0, 1'b0, rd);
            chk(wr_count == wc + 1, "R3 one strobe", wr_count - wc, 1);
            chk(last_addr == VECS[v][14:8], "R2 write address", last_addr, VECS[v][14:8]);
            chk(last_data == VECS[v][7:0], "R3 write data", last_data, VECS[v][7:0]);
            oe_bad = 0;
            framed(1'b1, VECS[v][14:8], 8'h00, 1'b0, 1'b0, rd);
            chk(rd == VECS[v][7:0], "R4 read data sdo", rd, VECS[v][7:0]);
            chk(oe_bad == 0, "R4 enable window", oe_bad, 0);
        end

        // R8: pause a write between instruction and data
        wc = wr_count;
        cs_lo();
        byte_io({1'b0, 7'h12}, 1'b0, 1'b0, 1'b0, rd);
        cs_hi();
        chk(wr_count == wc, "R8 no write while paused", wr_count - wc, 0);
        cs_lo();
        byte_io(8'h5A, 1'b0, 1'b0, 1'b0, rd);
        repeat (HALF) @(negedge clk);
        cs_hi();
        chk(last_addr == 7'h12 && last_data == 8'h5A, "R8 resumed write",
            {last_addr, last_data}, {7'h12, 8'h5A});

        // R8 R7: pause a read after its data byte is loaded
        oe_bad = 0;
        cs_lo();
        byte_io({1'b1, 7'h12}, 1'b0, 1'b0, 1'b0, rd);
        repeat (HALF) @(negedge clk);
        cs_hi();
        chk(!sdio_oe && !sdo_oe, "R7 released while paused", {sdio_oe, sdo_oe}, 0);
        cs_lo();
        byte_io(8'h00, 1'b0, 1'b0, 1'b1, rd);
        chk(rd == 8'h5A, "R8 resumed read data", rd, 8'h5A);
        repeat (HALF) @(negedge clk);
        chk(!sdo_oe, "R6 enable drops after byte", sdo_oe, 0);
        cs_hi();
        chk(oe_bad == 0, "R8 enable window after resume", oe_bad, 0);

        // R9: abort in the instruction byte, then a clean write
        cs_lo();
        for (int i = 0; i < 5; i++) begin
            bit s;
            one_bit(1'b1, 1'b0, 1'b0, s);
        end
        cs_hi();
        framed(1'b0, 7'h20, 8'h3C, 1'b0, 1'b0, rd);
        chk(last_addr == 7'h20 && last_data == 8'h3C, "R9 restart after abort",
            {last_addr, last_data}, {7'h20, 8'h3C});

        // R9: abort in the data byte discards the write
        wc = wr_count;
        cs_lo();
        byte_io({1'b0, 7'h21}, 1'b0, 1'b0, 1'b0, rd);
        for (int i = 0; i < 3; i++) begin
            bit s;
            one_bit(1'b1, 1'b0, 1'b0, s);
        end
        cs_hi();
        chk(wr_count == wc, "R9 no write after data abort", wr_count - wc, 0);
        framed(1'b1, 7'h21, 8'h00, 1'b0, 1'b0, rd);
        chk(rd == 8'h00, "R9 register untouched", rd, 8'h00);

        // R12: two transactions under one select
        wc = wr_count;
        cs_lo();
        xact(1'b0, 7'h30, 8'h11, 1'b0, 1'b0, rd);
        xact(1'b0, 7'h31, 8'h22, 1'b0, 1'b0, rd);
        cs_hi();
        chk(wr_count == wc + 2, "R12 back-to-back writes", wr_count - wc, 2);
        chk(last_addr == 7'h31 && last_data == 8'h22, "R12 second write",
            {last_addr, last_data}, {7'h31, 8'h22});

        // R10 R5: switch to 3-wire via register 0
        wc = wr_count;
        framed(1'b0, 7'h00, 8'h80, 1'b0, 1'b0, rd);
        chk(wr_count == wc, "R10 reg0 not forwarded", wr_count - wc, 0);
        oe_bad = 0;
        framed(1'b1, 7'h00, 8'h00, 1'b0, 1'b1, rd);
        chk(rd == 8'h80, "R10 reg0 readback", rd, 8'h80);
        cs_lo();
        xact(1'b1, 7'h31, 8'h00, 1'b0, 1'b1, rd);
        chk(!sdio_oe, "R6 shared line released after byte", sdio_oe, 0);
        cs_hi();
        chk(rd == 8'h22, "R5 read on shared line", rd, 8'h22);
        chk(oe_bad == 0, "R5 only shared line driven", oe_bad, 0);

        // R11: LSB first for both bytes
        framed(1'b0, 7'h00, 8'hC0, 1'b0, 1'b1, rd);
        framed(1'b1, 7'h00, 8'h00, 1'b1, 1'b1, rd);
        chk(rd == 8'hC0, "R11 reg0 read LSB first", rd, 8'hC0);
        framed(1'b0, 7'h33, 8'hA5, 1'b1, 1'b1, rd);
        chk(last_addr == 7'h33 && last_data == 8'hA5, "R11 LSB first write",
            {last_addr, last_data}, {7'h33, 8'hA5});

        // R11 R4 R12: mode change then read under one select
        oe_bad = 0;
        cs_lo();
        xact(1'b0, 7'h00, 8'h40, 1'b1, 1'b1, rd);
        xact(1'b1, 7'h33, 8'h00, 1'b1, 1'b0, rd);
        chk(rd == 8'hA5, "R11 order applies to next instruction", rd, 8'hA5);
        xact(1'b0, 7'h00, 8'h00, 1'b1, 1'b0, rd);
        xact(1'b1, 7'h00, 8'h00, 1'b0, 1'b0, rd);
        cs_hi();
        chk(rd == 8'h00, "R10 defaults restored", rd, 8'h00);
        chk(oe_bad == 0, "R4 enables across mode change", oe_bad, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule